// File: doc/BRIEF.md
# Multi-Supply Reset Supervisor Controller

This block is the digital half of a supply supervisor. Three external comparators report whether their supplies are healthy, a fourth reports the power-fail sense input, and a processor toggles a kick pin to prove it is alive. The controller holds a system reset while any monitored supply is low. Once every supply is good again, it keeps reset asserted for a chosen timeout. It runs a watchdog that forces one full reset pulse when the kick pin goes quiet. It also mirrors the power-fail comparator onto an active-low flag.

All time is measured in pulses of a free-running tick input, which normally comes from a divided on-chip oscillator at about 1 ms per tick. Every tick count is a parameter, so a bench can shrink the periods. The comparator flags, the kick pin and the watchdog enable are asynchronous. Each one passes through a two-flop synchronizer before any logic uses it. The reset output style (active low, active high or open drain) is chosen at build time.

Top module: `supply_supervisor`

## Requirements
- R1: When any bit of `supply_ok` is 0 (supply below threshold), reset is asserted from the clock edge after the synchronized value reaches the logic, and it stays asserted while that bit stays 0.
- R2: Reset releases only after the selected number of ticks has been counted with all three supplies good. A supply that drops inside that window restarts the count from zero.
- R3: `tmo_sel` picks the timeout: 2'b00 gives TMO_T0 ticks (50 ms nominal), 2'b01 gives TMO_T1 (100 ms), 2'b10 gives TMO_T2 (200 ms, the default strapping) and 2'b11 gives TMO_T3 (400 ms).
- R4: With the watchdog enabled and no kick edge, the watchdog expires after WD_TICKS ticks (1.6 s nominal, within 1.2 s to 2.0 s).
- R5: The watchdog count clears on both rising and falling edges of the synchronized kick. It is held at zero for every cycle in which reset is asserted.
- R6: A watchdog expiry asserts reset for exactly one selected timeout period, after which reset releases if all supplies are good.
- R7: While `wd_enable` is 0 (kick pin left floating), the watchdog is serviced internally and never causes a reset.
- R8: Output style follows RST_STYLE. RST_ACT_LOW drives `rst_out`=0 while reset is asserted. RST_ACT_HIGH drives `rst_out`=1. RST_OPEN_DRAIN drives `rst_out`=0 and `rst_drive_low`=1. `rst_drive_low` is 0 in the other two styles.
- R9: `pfail_n` equals `pf_ok` delayed by the two synchronizer stages: it is 0 when the power-fail comparator reports its input below threshold. It does not depend on reset or watchdog state.
- R10: After `rst_n` is released, reset stays asserted and a full selected timeout is counted before the first release.
- R11: A kick pulse that is high for only a single clock period is recognised as a transition and services the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| tick | input | 1 | Timebase pulse, one clock wide, synchronous to clk |
| supply_ok | input | 3 | Asynchronous supply-good flags, 1 = above threshold |
| pf_ok | input | 1 | Asynchronous power-fail comparator, 1 = above threshold |
| kick | input | 1 | Asynchronous watchdog kick pin |
| wd_enable | input | 1 | Asynchronous watchdog enable, 0 = kick pin floating |
| tmo_sel | input | 2 | Reset timeout select |
| rst_out | output | 1 | Reset output with the polarity chosen by RST_STYLE |
| rst_drive_low | output | 1 | Pull-down enable in open-drain style |
| pfail_n | output | 1 | Active-low power-fail flag |

## Verification
The watchdog expiry and a supply drop can both try to start a reset on the same clock edge. The watchdog counter also has to clear at the moment a new reset begins. The bench provokes this by tracking its own watchdog model until the count reaches its last value. It then drops one supply at offsets of zero to three cycles from that point, so the synchronized drop lands before, on, and after the expiry edge. A cycle-level reference model computes each expected output. In every case the result must be one reset that lasts a full timeout measured from the last supply recovery, with no second pulse from a stale watchdog.

// File: rtl/supv_pkg.sv
// Package: shared types for the supply supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package supv_pkg;

    // Electrical style of the reset pin, fixed at build time.
    typedef enum logic [1:0] {
        RST_ACT_LOW    = 2'd0,
        RST_ACT_HIGH   = 2'd1,
        RST_OPEN_DRAIN = 2'd2
    } rst_style_e;

    // Number of monitored supplies.
    localparam int unsigned N_SUPPLIES = 3;

    // Bit positions inside the synchronized input vector.
    localparam int unsigned IDX_PF   = N_SUPPLIES;
    localparam int unsigned IDX_KICK = N_SUPPLIES + 1;
    localparam int unsigned IDX_WDEN = N_SUPPLIES + 2;
    localparam int unsigned N_ASYNC  = N_SUPPLIES + 3;

endpackage

// File: rtl/supv_sync.sv
// Module: supv_sync
// Two-flop synchronizer bank, one independent chain per bit.
// Assumes: each input bit is an independent level; no bus coherency is needed.
// Reset clears both stages to zero, so a supply reads "low" until real data arrives.
module supv_sync #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_chain
            logic stage1;
            logic stage2;

            // Purpose: capture the asynchronous level, then let it settle one stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage1 <= 1'b0;
                    stage2 <= 1'b0;
                end else begin
                    stage1 <= async_in[b];
                    stage2 <= stage1;
                end
            end

            assign sync_out[b] = stage2;
        end
    endgenerate

endmodule

// File: rtl/supv_watchdog.sv
// Module: supv_watchdog
// Counts ticks since the last kick edge and emits a one-cycle expiry pulse.
// Assumes: kick_s and enable_s are already synchronized; hold is the live reset state.
// Both kick edges service the counter; hold and a cleared enable keep it at zero.
module supv_watchdog #(
    parameter int unsigned WD_TICKS = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic kick_s,
    input  logic enable_s,
    input  logic hold,
    output logic expire,
    output logic idle
);

    localparam int unsigned CW = (WD_TICKS > 1) ? $clog2(WD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

    logic [CW-1:0] count;
    logic          kick_prev;
    logic          kick_edge;

    // Purpose: detect either kick transition from the previous synchronized sample.
    assign kick_edge = kick_s ^ kick_prev;

    // Purpose: remember the previous kick level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kick_prev <= 1'b0;
        end else begin
            kick_prev <= kick_s;
        end
    end

    // Purpose: advance, clear or expire the watchdog count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (hold || !enable_s || kick_edge) begin
                count <= '0;
            end else if (tick) begin
                if (count == LAST) begin
                    count  <= '0;
                    expire <= 1'b1;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end

    // Purpose: report the cleared state for the checker.
    assign idle = (count == '0);

endmodule

// File: rtl/supv_reset_timer.sv
// Module: supv_reset_timer
// Holds reset while a supply is low or after a watchdog expiry, then counts the
// selected number of ticks with all supplies good before releasing.
// Assumes: every timeout parameter is at least 1; supplies are synchronized.
module supv_reset_timer #(
    parameter int unsigned N_SUP  = 3,
    parameter int unsigned TMO_T0 = 50,
    parameter int unsigned TMO_T1 = 100,
    parameter int unsigned TMO_T2 = 200,
    parameter int unsigned TMO_T3 = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [N_SUP-1:0] sup_ok_s,
    input  logic             wd_expire,
    input  logic [1:0]       tmo_sel,
    output logic             active
);

    localparam int unsigned MAX01 = (TMO_T0 > TMO_T1) ? TMO_T0 : TMO_T1;
    localparam int unsigned MAX23 = (TMO_T2 > TMO_T3) ? TMO_T2 : TMO_T3;
    localparam int unsigned TMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int unsigned TW    = (TMAX > 1) ? $clog2(TMAX) : 1;

    logic [TW-1:0] count;
    logic [TW-1:0] last;
    logic          all_ok;

    // Purpose: all monitored supplies report good.
    assign all_ok = &sup_ok_s;

    // Purpose: map the timeout select onto its final count value.
    always_comb begin
        unique case (tmo_sel)
            2'b00:   last = TW'(TMO_T0 - 1);
            2'b01:   last = TW'(TMO_T1 - 1);
            2'b10:   last = TW'(TMO_T2 - 1);
            default: last = TW'(TMO_T3 - 1);
        endcase
    end

    // Purpose: assert, restart or time out the reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            count  <= '0;
        end else if (!all_ok || wd_expire) begin
            active <= 1'b1;
            count  <= '0;
        end else if (active && tick) begin
            if (count == last) begin
                active <= 1'b0;
                count  <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/supply_supervisor.sv
// Module: supply_supervisor (top)
// Digital control of a three-supply reset supervisor with watchdog and
// power-fail flag. All asynchronous pins are synchronized here.
// Assumes: tick is a single-cycle pulse synchronous to clk; timeouts >= 1 tick.
module supply_supervisor
    import supv_pkg::*;
#(
    parameter int unsigned TMO_T0   = 50,
    parameter int unsigned TMO_T1   = 100,
    parameter int unsigned TMO_T2   = 200,
    parameter int unsigned TMO_T3   = 400,
    parameter int unsigned WD_TICKS = 1600,
    parameter rst_style_e  RST_STYLE = RST_ACT_LOW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [N_SUPPLIES-1:0] supply_ok,
    input  logic                  pf_ok,
    input  logic                  kick,
    input  logic                  wd_enable,
    input  logic [1:0]            tmo_sel,
    output logic                  rst_out,
    output logic                  rst_drive_low,
    output logic                  pfail_n
);

    logic [N_ASYNC-1:0]    async_vec;
    logic [N_ASYNC-1:0]    sync_vec;
    logic [N_SUPPLIES-1:0] sup_s;
    logic                  pf_s;
    logic                  kick_s;
    logic                  wd_en_s;
    logic                  rst_active;
    logic                  wd_fire;
    logic                  wd_idle;

    // Purpose: gather all asynchronous pins into one synchronizer bank.
    assign async_vec = {wd_enable, kick, pf_ok, supply_ok};

    supv_sync #(
        .WIDTH (N_ASYNC)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (async_vec),
        .sync_out (sync_vec)
    );

    // Purpose: split the synchronized vector back into named levels.
    assign sup_s   = sync_vec[N_SUPPLIES-1:0];
    assign pf_s    = sync_vec[IDX_PF];
    assign kick_s  = sync_vec[IDX_KICK];
    assign wd_en_s = sync_vec[IDX_WDEN];

    supv_watchdog #(
        .WD_TICKS (WD_TICKS)
    ) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .kick_s   (kick_s),
        .enable_s (wd_en_s),
        .hold     (rst_active),
        .expire   (wd_fire),
        .idle     (wd_idle)
    );

    supv_reset_timer #(
        .N_SUP  (N_SUPPLIES),
        .TMO_T0 (TMO_T0),
        .TMO_T1 (TMO_T1),
        .TMO_T2 (TMO_T2),
        .TMO_T3 (TMO_T3)
    ) u_rtmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sup_ok_s  (sup_s),
        .wd_expire (wd_fire),
        .tmo_sel   (tmo_sel),
        .active    (rst_active)
    );

    // Purpose: power-fail flag follows its comparator only.
    assign pfail_n = pf_s;

    // Purpose: shape the reset pin for the selected electrical style.
    generate
        if (RST_STYLE == RST_ACT_HIGH) begin : g_high
            assign rst_out       = rst_active;
            assign rst_drive_low = 1'b0;
        end else if (RST_STYLE == RST_OPEN_DRAIN) begin : g_od
            assign rst_out       = ~rst_active;
            assign rst_drive_low = rst_active;
        end else begin : g_low
            assign rst_out       = ~rst_active;
            assign rst_drive_low = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/supv_checker.sv
// Module: supv_checker
// Temporal properties of the supervisor, attached to the top by bind.
// Assumes: signals are sampled on the rising clock edge.
module supv_checker #(
    parameter int unsigned N_SUP = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [N_SUP-1:0] sup_s,
    input logic             wd_en_s,
    input logic             pf_raw,
    input logic             pfail_n,
    input logic             rst_active,
    input logic             wd_fire,
    input logic             wd_idle
);

    // A low supply forces reset on the following edge.
    assert_low_supply_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(&sup_s) |=> rst_active);

    // Release happens only on a tick with every supply good.
    assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active) |-> ($past(tick) && $past(&sup_s)));

    // Watchdog count stays cleared during reset.
    assert_wd_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |=> wd_idle);

    // Expiry starts a reset.
    assert_wd_starts_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fire |=> rst_active);

    // Disabled watchdog never expires.
    assert_wd_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en_s |=> !wd_fire);

    // Power-fail flag is the comparator two edges late.
    assert_pfail_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (pfail_n == $past(pf_raw, 2)));

endmodule

bind supply_supervisor supv_checker #(
    .N_SUP (supv_pkg::N_SUPPLIES)
) u_supv_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .sup_s      (sup_s),
    .wd_en_s    (wd_en_s),
    .pf_raw     (pf_ok),
    .pfail_n    (pfail_n),
    .rst_active (rst_active),
    .wd_fire    (wd_fire),
    .wd_idle    (wd_idle)
);

// File: tb/test_supply_supervisor.sv
// Bench: test_supply_supervisor
// Cycle-level reference model plus directed and seeded random stimulus.
module test_supply_supervisor;
    import supv_pkg::*;

    localparam int T0 = 3;
    localparam int T1 = 5;
    localparam int T2 = 9;
    localparam int T3 = 14;
    localparam int WDT = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] sup = 3'b111;
    logic       pf = 1'b1;
    logic       kick = 1'b0;
    logic       wden = 1'b1;
    logic [1:0] sel = 2'b10;

    logic lo_rst, lo_dl, lo_pf;
    logic hi_rst, hi_dl, hi_pf;
    logic od_rst, od_dl, od_pf;

    always #4 clk = ~clk;

    supply_supervisor #(.TMO_T0(T0), .TMO_T1(T1), .TMO_T2(T2), .TMO_T3(T3),
        .WD_TICKS(WDT), .RST_STYLE(RST_ACT_LOW)) i_supply_supervisor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(sup), .pf_ok(pf),
        .kick(kick), .wd_enable(wden), .tmo_sel(sel),
        .rst_out(lo_rst), .rst_drive_low(lo_dl), .pfail_n(lo_pf));

    supply_supervisor #(.TMO_T0(T0), .TMO_T1(T1), .TMO_T2(T2), .TMO_T3(T3),
        .WD_TICKS(WDT), .RST_STYLE(RST_ACT_HIGH)) i_supply_supervisor_hi (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(sup), .pf_ok(pf),
        .kick(kick), .wd_enable(wden), .tmo_sel(sel),
        .rst_out(hi_rst), .rst_drive_low(hi_dl), .pfail_n(hi_pf));

    supply_supervisor #(.TMO_T0(T0), .TMO_T1(T1), .TMO_T2(T2), .TMO_T3(T3),
        .WD_TICKS(WDT), .RST_STYLE(RST_OPEN_DRAIN)) i_supply_supervisor_od (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(sup), .pf_ok(pf),
        .kick(kick), .wd_enable(wden), .tmo_sel(sel),
        .rst_out(od_rst), .rst_drive_low(od_dl), .pfail_n(od_pf));

    // Reference model state
    logic [5:0] s1 = '0, s2 = '0;
    logic kprev = 1'b0, m_rst = 1'b1, m_fire = 1'b0;
    int   m_cnt = 0, m_wd = 0;

    int    checks = 0, fails = 0, rises = 0;
    string ph = "R10";
    logic  prev_hi = 1'b1;
    bit    rand_tick = 1'b0;

    function automatic int lim(input logic [1:0] s);
        case (s)
            2'b00:   return T0;
            2'b01:   return T1;
            2'b10:   return T2;
            default: return T3;
        endcase
    endfunction

    task automatic model_step();
        logic any_low, ek, en, nr, nf;
        int nc, nw;
        if (!rst_n) begin
            s1 = '0; s2 = '0; kprev = 1'b0; m_rst = 1'b1; m_cnt = 0;
            m_wd = 0; m_fire = 1'b0;
            return;
        end
        any_low = ~&s2[2:0];
        ek = s2[4] ^ kprev;
        en = s2[5];
        nr = m_rst; nc = m_cnt;
        if (any_low || m_fire) begin
            nr = 1'b1; nc = 0;
        end else if (m_rst && tick) begin
            if (m_cnt == lim(sel) - 1) begin nr = 1'b0; nc = 0; end
            else nc = m_cnt + 1;
        end
        nf = 1'b0; nw = m_wd;
        if (m_rst || !en || ek) nw = 0;
        else if (tick) begin
            if (m_wd == WDT - 1) begin nw = 0; nf = 1'b1; end
            else nw = m_wd + 1;
        end
        kprev = s2[4];
        s2 = s1;
        s1 = {wden, kick, pf, sup};
        m_rst = nr; m_cnt = nc; m_wd = nw; m_fire = nf;
    endtask

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(ph, "R8 active-low rst_out", lo_rst, ~m_rst);
        check(ph, "R8 active-high rst_out", hi_rst, m_rst);
        check(ph, "R8 open-drain drive_low", od_dl, m_rst);
        check(ph, "R8 open-drain rst_out", od_rst, ~m_rst);
        check(ph, "R8 no pull-down in push-pull", lo_dl | hi_dl, 1'b0);
        check(ph, "R9 pfail_n", lo_pf, s2[3]);
        if (hi_rst && !prev_hi) rises++;
        prev_hi = hi_rst;
        tick = rand_tick ? 1'($urandom % 2) : ~tick;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic run_kicked(input int n, input int period);
        for (int i = 0; i < n; i++) begin
            if (i % period == 0) kick = ~kick;
            cyc();
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog timer expired actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        // R10: power-on
        ph = "R10 power-on";
        run(3);
        check("R10", "reset asserted at power-on", hi_rst, 1'b1);
        rst_n = 1'b1;
        run_kicked(40, 6);
        check("R10", "released after full timeout", hi_rst, 1'b0);

        // R3: each timeout select, R1 drop and hold
        for (int s = 0; s < 4; s++) begin
            ph = "R3 select";
            sel = 2'(s);
            sup[s % 3] = 1'b0;
            run_kicked(5, 6);
            check("R1", "reset held while supply low", hi_rst, 1'b1);
            sup = 3'b111;
            run_kicked(40, 6);
        end

        // R2: drop again inside the window restarts
        ph = "R2 restart";
        sel = 2'b10;
        sup[1] = 1'b0; run_kicked(3, 6);
        sup = 3'b111;  run_kicked(10, 6);
        sup[2] = 1'b0; run_kicked(2, 6);
        sup = 3'b111;  run_kicked(40, 6);

        // R4 R6: no kicks, watchdog fires
        ph = "R6 watchdog";
        sel = 2'b00;
        rises = 0;
        run(130);
        check("R6", "watchdog produced reset pulses", 1'(rises >= 2), 1'b1);

        // R5: both kick edges service the watchdog
        ph = "R5 kick edges";
        run_kicked(20, 5);
        rises = 0;
        run_kicked(150, 20);
        check("R5", "no watchdog reset with toggling kick", 1'(rises == 0), 1'b1);

        // R11: one-clock kick pulses
        ph = "R11 short kick";
        rises = 0;
        for (int i = 0; i < 150; i++) begin
            kick = (i % 30 == 0);
            cyc();
        end
        kick = 1'b0;
        check("R11", "single-cycle kick serviced", 1'(rises == 0), 1'b1);

        // R7: disabled watchdog
        ph = "R7 disabled";
        wden = 1'b0;
        rises = 0;
        run(200);
        check("R7", "disabled watchdog caused no reset", 1'(rises == 0), 1'b1);
        wden = 1'b1;

        // R9: power-fail independent of reset state
        ph = "R9 power-fail";
        for (int i = 0; i < 80; i++) begin
            pf = 1'($urandom % 2);
            if (i % 25 == 3) sup[0] = 1'b0;
            if (i % 25 == 6) sup[0] = 1'b1;
            cyc();
        end
        pf = 1'b1; sup = 3'b111;

        // R1 with R6: supply drop near the watchdog expiry edge
        for (int k = 0; k < 4; k++) begin
            ph = "R1 R6 collision";
            sel = 2'b01;
            for (int g = 0; g < 400 && !(m_wd == WDT - 1 && !m_rst); g++) cyc();
            run(k);
            sup[k % 3] = 1'b0;
            run(3);
            sup = 3'b111;
            run(40);
        end

        // Random mix
        ph = "R1 R2 R4 random";
        rand_tick = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            sup  = ($urandom % 40 == 0) ? 3'($urandom) : 3'b111;
            pf   = ($urandom % 8 != 0);
            if ($urandom % 12 == 0) kick = ~kick;
            wden = ($urandom % 50 != 0) ? 1'b1 : ~wden;
            if ($urandom % 300 == 0) sel = 2'($urandom);
            cyc();
        end
        summary();
    end

endmodule